// File: doc/BRIEF.md
# Oversampling Baud Generator

This block produces the timing strobes that a UART's receiver and transmitter run from. A modulo divisor splits the system clock into an oversample tick. A ratio field sets how many ticks make one bit period. Within each bit the block marks three points for the receiver: a mid-bit sample strobe and the sample point on each side of it, so that the receiver can take a three-sample majority vote. It also marks the bit boundary for the transmitter.

In both-edge mode the block also creates a half-period event inside each divisor period, which acts as the falling edge of the baud clock. The two neighbour strobes then sit half a tick on each side of the mid sample. This is what makes the short ratios of 4 to 7 usable. A receive edge pulse can restart the bit timing, which aligns the timing to a start bit. While the receiver is inside a character, a restart happens only if resynchronisation is allowed.

All strobes are one system clock wide and come from the registered counters in the same cycle. An integration needs no extra delay stage.

Top module: `os_baud_gen`

## Requirements
- R1: A divisor of 0 stops the generator: no strobe fires and `ovs_count` stays 0.
- R2: With divisor D ≥ 1, `ovs_tick` fires once every D clocks, in the cycle where the divisor counter holds D-1.
- R3: The ratio field maps to a ratio as follows. Values 7 to 31 give the field value plus one. Values 0, 1 and 2 give 16. The `ratio` output shows the effective ratio.
- R4: Field values 3 to 6 give the field value plus one only when `both_edge` is 1. Otherwise they give 16.
- R5: `bit_end` fires on the tick where `ovs_count` equals ratio-1. The count then returns to 0, so one bit lasts ratio × D clocks.
- R6: `sample_mid` fires on the tick where `ovs_count` equals ratio/2 (rounded down). At most one of the three sample strobes is high in any cycle.
- R7: With `both_edge` at 0, `sample_early` and `sample_late` fire on the ticks at counts ratio/2-1 and ratio/2+1.
- R8: With `both_edge` at 1 and D ≥ 2, the half-period point is divisor count ((D+1)>>1)-1. The neighbour strobes fire there, at counts ratio/2 (early) and ratio/2+1 (late). With D = 1 they never fire.
- R9: An `rx_edge` pulse with `rx_active` at 0 restarts the timing. In the first cycle after it, both counters are 0.
- R10: An `rx_edge` pulse with `rx_active` at 1 also restarts the timing, provided `resync_dis` is 0.
- R11: An `rx_edge` pulse with `rx_active` and `resync_dis` both at 1 has no effect on the counters or the strobes.
- R12: `ovs_count` equals the number of ticks since the last restart, modulo the ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| divisor | input | 13 | Modulo divisor; 0 disables |
| osr_field | input | 5 | Oversampling ratio field |
| both_edge | input | 1 | Sample on both baud-clock edges |
| resync_dis | input | 1 | Block restarts while a character is in progress |
| rx_edge | input | 1 | One-cycle pulse on a receive falling edge |
| rx_active | input | 1 | Receiver is inside a character |
| ovs_tick | output | 1 | Oversample tick (rising baud edge) |
| sample_early | output | 1 | Sample point before mid-bit |
| sample_mid | output | 1 | Mid-bit sample strobe |
| sample_late | output | 1 | Sample point after mid-bit |
| bit_end | output | 1 | Bit-boundary strobe |
| ovs_count | output | 5 | Oversample count within the bit |
| ratio | output | 6 | Effective oversampling ratio |

## Verification
The in-line properties check the following on every cycle:
- the counter wraps after each tick and after each bit boundary;
- the sample strobes are mutually exclusive and the mid strobe only fires on a tick;
- the count stays below the ratio;
- the ratio stays in its legal range for the chosen edge mode;
- a restart clears the counters, and an ignored edge pulse leaves them running.

Only the bench's sweeps can show that each strobe lands in exactly the right cycle. Those sweeps cover divisors and ratio fields in both edge modes and compare the strobe positions against an arithmetic model of time since restart. The dependence of restarts on `rx_active` and `resync_dis` is also shown there.

// File: rtl/obg_pkg.sv
package obg_pkg;
  localparam int DIV_W          = 13;
  localparam int OSR_W          = 5;
  localparam int FALLBACK_RATIO = 16;
  localparam int SINGLE_MIN_FLD = 7;
  localparam int BOTH_MIN_FLD   = 3;

  typedef struct packed {
    logic early;
    logic mid;
    logic late;
    logic bit_end;
  } obg_strobes_t;
endpackage

// File: rtl/obg_osr_decode.sv
module obg_osr_decode #(
  parameter int OSR_W      = obg_pkg::OSR_W,
  parameter int FALLBACK   = obg_pkg::FALLBACK_RATIO,
  parameter int SINGLE_MIN = obg_pkg::SINGLE_MIN_FLD,
  parameter int BOTH_MIN   = obg_pkg::BOTH_MIN_FLD,
  localparam int RATIO_W   = OSR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [OSR_W-1:0]   osr_field,
  input  logic               both_edge,
  output logic [RATIO_W-1:0] ratio
);
  // field+1 when legal for the edge mode, fallback otherwise
  function automatic logic [RATIO_W-1:0] decode_ratio(input logic [OSR_W-1:0] f,
                                                      input logic b);
    logic [RATIO_W-1:0] fe;
    fe = RATIO_W'(f);
    if (fe >= RATIO_W'(SINGLE_MIN))                 return fe + RATIO_W'(1);
    else if (b && (fe >= RATIO_W'(BOTH_MIN)))       return fe + RATIO_W'(1);
    else                                            return RATIO_W'(FALLBACK);
  endfunction

  assign ratio = decode_ratio(osr_field, both_edge);

  // R3: ratio never exceeds the counter capacity
  p_ratio_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ratio <= RATIO_W'(1 << OSR_W));
  // R4: single-edge mode never yields a short ratio
  p_ratio_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !both_edge |-> ratio >= RATIO_W'(SINGLE_MIN + 1));
  // R4: both-edge mode never yields a ratio below four
  p_ratio_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    both_edge |-> ratio >= RATIO_W'(BOTH_MIN + 1));
endmodule

// File: rtl/obg_prescaler.sv
module obg_prescaler #(
  parameter int DIV_W = obg_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             both_edge,
  input  logic             restart,
  output logic [DIV_W-1:0] dcnt,
  output logic             rise,
  output logic             fall
);
  // half-period point: ceil(d/2) - 1
  function automatic logic [DIV_W-1:0] half_point(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] up;
    up = ({1'b0, d} + (DIV_W+1)'(1)) >> 1;
    return DIV_W'(up) - DIV_W'(1);
  endfunction

  logic enabled;
  logic at_last;

  assign enabled = (divisor != '0);
  assign at_last = (dcnt >= divisor - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dcnt <= '0;
    else if (restart || !enabled)  dcnt <= '0;
    else if (at_last)              dcnt <= '0;
    else                           dcnt <= dcnt + DIV_W'(1);
  end

  assign rise = enabled && !restart && at_last;
  assign fall = enabled && !restart && both_edge && (divisor >= DIV_W'(2)) &&
                (dcnt == half_point(divisor));

  // R2: the divisor counter restarts after each tick
  p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> dcnt == '0);
  // R1: a zero divisor holds the counter at zero
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> dcnt == '0);
  // R8: the half-period event never coincides with a tick
  p_fall_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall));
endmodule

// File: rtl/obg_ovs_counter.sv
module obg_ovs_counter #(
  parameter int OSR_W   = obg_pkg::OSR_W,
  localparam int RATIO_W = OSR_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enabled,
  input  logic                  restart,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  both_edge,
  input  logic [RATIO_W-1:0]    ratio,
  output logic [OSR_W-1:0]      ovs,
  output obg_pkg::obg_strobes_t strobes
);
  logic [RATIO_W-1:0] cnt_ext;
  logic [RATIO_W-1:0] half;
  logic               at_top;

  assign cnt_ext = RATIO_W'(ovs);
  assign half    = ratio >> 1;
  assign at_top  = (cnt_ext >= ratio - RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ovs <= '0;
    else if (restart || !enabled)  ovs <= '0;
    else if (rise)                 ovs <= at_top ? '0 : ovs + OSR_W'(1);
  end

  assign strobes.bit_end = rise && at_top;
  assign strobes.mid     = rise && (cnt_ext == half);

  generate
    if (1) begin : g_neighbours
      logic early_single, late_single, early_both, late_both;
      assign early_single = rise && (cnt_ext == half - RATIO_W'(1));
      assign late_single  = rise && (cnt_ext == half + RATIO_W'(1));
      assign early_both   = fall && (cnt_ext == half);
      assign late_both    = fall && (cnt_ext == half + RATIO_W'(1));
      assign strobes.early = both_edge ? early_both : early_single;
      assign strobes.late  = both_edge ? late_both  : late_single;
    end
  endgenerate

  // R5: a bit boundary returns the count to zero
  p_bit_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.bit_end |=> ovs == '0);
  // R6: the three sample strobes are mutually exclusive
  p_sample_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobes.early, strobes.mid, strobes.late}));
  // R6: the mid strobe only appears on a tick
  p_mid_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.mid |-> rise);
  // R12: the count stays below a steady ratio
  p_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ext < ratio) |=> ((cnt_ext < ratio) || (ratio != $past(ratio))));
endmodule

// File: rtl/os_baud_gen.sv
module os_baud_gen #(
  parameter int DIV_W   = obg_pkg::DIV_W,
  parameter int OSR_W   = obg_pkg::OSR_W,
  localparam int RATIO_W = OSR_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIV_W-1:0]   divisor,
  input  logic [OSR_W-1:0]   osr_field,
  input  logic               both_edge,
  input  logic               resync_dis,
  input  logic               rx_edge,
  input  logic               rx_active,
  output logic               ovs_tick,
  output logic               sample_early,
  output logic               sample_mid,
  output logic               sample_late,
  output logic               bit_end,
  output logic [OSR_W-1:0]   ovs_count,
  output logic [RATIO_W-1:0] ratio
);
  logic                  restart;
  logic                  enabled;
  logic                  rise_w;
  logic                  fall_w;
  logic [DIV_W-1:0]      dcnt_w;
  obg_pkg::obg_strobes_t strobes_w;

  assign enabled = (divisor != '0);
  // restart from idle always; inside a character only when allowed
  assign restart = rx_edge && (!rx_active || !resync_dis);

  obg_osr_decode #(.OSR_W(OSR_W)) u_decode (
    .clk(clk), .rst_n(rst_n), .osr_field(osr_field),
    .both_edge(both_edge), .ratio(ratio)
  );

  obg_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .both_edge(both_edge),
    .restart(restart), .dcnt(dcnt_w), .rise(rise_w), .fall(fall_w)
  );

  obg_ovs_counter #(.OSR_W(OSR_W)) u_ovs (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .restart(restart),
    .rise(rise_w), .fall(fall_w), .both_edge(both_edge), .ratio(ratio),
    .ovs(ovs_count), .strobes(strobes_w)
  );

  assign ovs_tick     = rise_w;
  assign sample_early = strobes_w.early;
  assign sample_mid   = strobes_w.mid;
  assign sample_late  = strobes_w.late;
  assign bit_end      = strobes_w.bit_end;

  // R1: no strobe leaves a disabled generator
  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !(ovs_tick || sample_early || sample_mid || sample_late || bit_end));
  // R9: a restart leaves both counters at zero
  p_restart_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ovs_count == '0) && (dcnt_w == '0));
  // R10: an allowed in-character edge clears the count
  p_resync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_edge && rx_active && !resync_dis) |=> ovs_count == '0);
  // R11: a blocked edge lets the divisor counter keep running
  p_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_edge && rx_active && resync_dis && enabled && !rise_w) |=>
      ((dcnt_w == $past(dcnt_w) + DIV_W'(1)) || (divisor != $past(divisor))));
endmodule

// File: tb/os_baud_gen_tb.sv
`timescale 1ns/1ps
module os_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] divisor = '0;
  logic [4:0]  osr_field = '0;
  logic        both_edge = 1'b0;
  logic        resync_dis = 1'b0;
  logic        rx_edge = 1'b0;
  logic        rx_active = 1'b0;
  logic        ovs_tick, sample_early, sample_mid, sample_late, bit_end;
  logic [4:0]  ovs_count;
  logic [5:0]  ratio;

  int n_checks = 0;
  int n_fail = 0;
  int t = 0;
  int cur_div = 0;
  int cur_r = 16;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  os_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .osr_field(osr_field),
    .both_edge(both_edge), .resync_dis(resync_dis), .rx_edge(rx_edge),
    .rx_active(rx_active), .ovs_tick(ovs_tick), .sample_early(sample_early),
    .sample_mid(sample_mid), .sample_late(sample_late), .bit_end(bit_end),
    .ovs_count(ovs_count), .ratio(ratio)
  );

  task automatic check(input string what, input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at t=%0d div=%0d: actual %0d expected %0d",
               req, what, t, cur_div, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int f, input bit b);
    if (f > 6) return f + 1;
    if (b && f > 2) return f + 1;
    return 16;
  endfunction

  // expected outputs from elapsed clocks since restart
  task automatic check_window();
    int ov, dc, hf;
    bit r, fl, e_exp, l_exp;
    ov = (t / cur_div) % cur_r;
    dc = t % cur_div;
    hf = cur_r / 2;
    r  = (dc == cur_div - 1);
    fl = both_edge && (cur_div >= 2) && (dc == (cur_div - 1) / 2);
    if (both_edge) begin
      e_exp = fl && (ov == hf);
      l_exp = fl && (ov == hf + 1);
    end else begin
      e_exp = r && (ov == hf - 1);
      l_exp = r && (ov == hf + 1);
    end
    check("ovs_tick", "R2", int'(ovs_tick), int'(r));
    check("ovs_count", "R12", int'(ovs_count), ov);
    check("bit_end", "R5", int'(bit_end), int'(r && (ov == cur_r - 1)));
    check("sample_mid", "R6", int'(sample_mid), int'(r && (ov == hf)));
    check("sample_early", both_edge ? "R8" : "R7", int'(sample_early), int'(e_exp));
    check("sample_late", both_edge ? "R8" : "R7", int'(sample_late), int'(l_exp));
  endtask

  task automatic step();
    @(negedge clk); #1;
    t++;
    check_window();
  endtask

  task automatic pulse_edge(input bit active, input bit dis, input bit restarts);
    rx_edge = 1'b1; rx_active = active; resync_dis = dis;
    @(negedge clk);
    rx_edge = 1'b0; rx_active = 1'b0;
    #1;
    t = restarts ? 0 : t + 1;
    check_window();
  endtask

  task automatic run_cfg(input int d, input int f, input bit b);
    divisor = 13'(d); osr_field = 5'(f); both_edge = b;
    cur_div = d;
    cur_r = exp_ratio(f, b);
    #1;
    check("ratio", (f > 2 && f < 7) ? "R4" : "R3", int'(ratio), cur_r);
    pulse_edge(1'b0, 1'b0, 1'b1);  // R9
    for (int k = 0; k < 2 * cur_r * d + 4; k++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog all-requirements: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int divs[4];
    int flds[9];
    divs = '{1, 2, 3, 5};
    flds = '{0, 1, 2, 3, 4, 6, 7, 15, 31};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("reset ovs_count", "R1", int'(ovs_count), 0);
    check("reset strobes", "R1",
          int'({ovs_tick, sample_early, sample_mid, sample_late, bit_end}), 0);

    // R1: zero divisor keeps everything quiet
    divisor = '0; osr_field = 5'd7;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); #1;
      check("off strobes R1", "R1",
            int'({ovs_tick, sample_early, sample_mid, sample_late, bit_end}), 0);
      check("off count R1", "R1", int'(ovs_count), 0);
    end

    // sweep of divisors, ratio fields and edge modes
    for (int bi = 0; bi < 2; bi++)
      for (int di = 0; di < 4; di++)
        for (int fi = 0; fi < 9; fi++)
          run_cfg(divs[di], flds[fi], bit'(bi));

    // R11: blocked in-character edge changes nothing
    run_cfg(3, 15, 1'b0);
    for (int k = 0; k < 20; k++) step();
    pulse_edge(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 60; k++) step();

    // R10: allowed in-character edge restarts the timing
    for (int k = 0; k < 17; k++) step();
    pulse_edge(1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 60; k++) step();

    // R9: idle-line edge restarts even with resync blocked
    for (int k = 0; k < 11; k++) step();
    pulse_edge(1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 60; k++) step();

    // R8: both-edge short ratio with a blocked edge mid-stream
    run_cfg(4, 3, 1'b1);
    for (int k = 0; k < 9; k++) step();
    pulse_edge(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 40; k++) step();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule